// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block is the purely combinational next-instruction-address logic of a single-cycle 32-bit processor. Each cycle it receives the current program counter, the instruction's 16-bit immediate and 26-bit jump field, the two register operands read for the instruction, and the decoder's control lines. From these it produces the address of the next instruction and the sequential address (PC + 4). The sequential address also serves as the return address that a jump-and-link writes into register 31.

The unit decides branch outcomes itself from the operand values and does not depend on an arithmetic unit's zero flag. Four conditional forms are supported: equality, signed less-or-equal, non-zero, and negative. When several control lines are active at once, a register-indirect jump wins, then an absolute jump, then a taken branch, and otherwise the address advances by four. The PC register, instruction fetch and register file are outside this block.

Top module: `npc_unit`

## Requirements
- R1: With branch, jump and jump-register controls all low, `npc_o` equals `pc_i + 4` (modulo 2^32).
- R2: `link_o` always equals `pc_i + 4` modulo 2^32, whatever the controls; at `pc_i = 0xFFFFFFFC` it is 0.
- R3: A taken branch sets `npc_o` to `pc_i + 4 + (sign-extended imm_i << 2)`, for both positive (forward) and negative (backward) offsets.
- R4: A branch is taken only when `br_en_i` is 1 and the condition selected by `br_kind_i` holds; with `br_en_i` at 0 the condition is ignored and `npc_o` is `pc_i + 4`. `br_kind_i = 2'b00` selects equality: taken when `rs_val_i == rt_val_i`.
- R5: `br_kind_i = 2'b01` is taken when `rs_val_i <= rt_val_i` as signed two's-complement values.
- R6: `br_kind_i = 2'b10` is taken when `rs_val_i != 0`; `rt_val_i` has no effect.
- R7: `br_kind_i = 2'b11` is taken when bit 31 of `rs_val_i` is 1; `rt_val_i` has no effect.
- R8: With `jmp_i` at 1 (and `jreg_i` at 0), `npc_o` is `{pc_i[31:28], jaddr_i, 2'b00}`.
- R9: With `jreg_i` at 1, `npc_o` equals `rs_val_i`.
- R10: Priority is `jreg_i`, then `jmp_i`, then a taken branch, then sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current program counter |
| imm_i | input | 16 | Branch offset in words, signed |
| jaddr_i | input | 26 | Absolute jump word address field |
| rs_val_i | input | 32 | First register operand (also jump-register target) |
| rt_val_i | input | 32 | Second register operand |
| br_en_i | input | 1 | Decoder: instruction is a conditional branch |
| br_kind_i | input | 2 | Branch condition: 00 equal, 01 signed less-or-equal, 10 non-zero, 11 negative |
| jmp_i | input | 1 | Decoder: absolute jump (j or jal) |
| jreg_i | input | 1 | Decoder: jump to register value |
| npc_o | output | 32 | Next program counter |
| link_o | output | 32 | PC + 4, sequential address and return-link value |

## Verification
Since the unit holds no state, any fault shows in the same cycle at `npc_o` or `link_o`, so each vector is compared before the next one is applied. A wrong condition decode appears as a branch going the wrong way, so the stimulus uses operand pairs where signed and unsigned comparison disagree, and pairs where only `rt_val_i` changes for the single-operand forms. A wrong offset extension or shift shows as a target off by a sign or factor of four, which forward and backward offsets expose. A wrong priority shows only when control lines overlap, so vectors assert several of them together.

// File: rtl/npc_pkg.sv
package npc_pkg;

   typedef enum logic [1:0] {
      BRK_EQ  = 2'b00,
      BRK_LE  = 2'b01,
      BRK_NEZ = 2'b10,
      BRK_LTZ = 2'b11
   } br_kind_e;

   typedef enum logic [1:0] {
      SEL_SEQ = 2'b00,
      SEL_BR  = 2'b01,
      SEL_ABS = 2'b10,
      SEL_REG = 2'b11
   } npc_sel_e;

endpackage

// File: rtl/npc_adders.sv
module npc_adders #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [IMM_W-1:0] imm,
   output logic [XLEN-1:0]  seq_addr,
   output logic [XLEN-1:0]  br_addr
);
   localparam int EXT_W = XLEN - IMM_W - 2;
   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   logic [XLEN-1:0] offs;

   assign offs     = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
   assign seq_addr = pc + STEP;
   assign br_addr  = seq_addr + offs;
endmodule

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit LE_VIA_SUB = 1'b0
) (
   input  logic [XLEN-1:0] rs,
   input  logic [XLEN-1:0] rt,
   input  br_kind_e        kind,
   output logic            cond
);
   logic eq_hit;
   logic le_hit;
   logic nez_hit;
   logic ltz_hit;

   assign eq_hit  = (rs == rt);
   assign nez_hit = |rs;
   assign ltz_hit = rs[XLEN-1];

   generate
      if (LE_VIA_SUB) begin : g_le_sub
         logic [XLEN:0] diff;
         assign diff   = {rs[XLEN-1], rs} - {rt[XLEN-1], rt};
         assign le_hit = diff[XLEN] | (diff == '0);
      end else begin : g_le_cmp
         assign le_hit = ($signed(rs) <= $signed(rt));
      end
   endgenerate

   always_comb begin
      unique case (kind)
         BRK_EQ:  cond = eq_hit;
         BRK_LE:  cond = le_hit;
         BRK_NEZ: cond = nez_hit;
         BRK_LTZ: cond = ltz_hit;
         default: cond = 1'b0;
      endcase
   end
endmodule

// File: rtl/npc_select.sv
module npc_select
   import npc_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int JADDR_W = 26
) (
   input  logic [XLEN-1:0]    pc,
   input  logic [XLEN-1:0]    seq_addr,
   input  logic [XLEN-1:0]    br_addr,
   input  logic [JADDR_W-1:0] jaddr,
   input  logic [XLEN-1:0]    reg_addr,
   input  logic               br_en,
   input  logic               cond,
   input  logic               jmp,
   input  logic               jreg,
   output npc_sel_e           sel,
   output logic [XLEN-1:0]    npc
);
   localparam int REGION_W = XLEN - JADDR_W - 2;

   logic [XLEN-1:0] abs_addr;

   assign abs_addr = {pc[XLEN-1 -: REGION_W], jaddr, 2'b00};

   always_comb begin
      if (jreg)
         sel = SEL_REG;
      else if (jmp)
         sel = SEL_ABS;
      else if (br_en && cond)
         sel = SEL_BR;
      else
         sel = SEL_SEQ;
   end

   always_comb begin
      unique case (sel)
         SEL_REG: npc = reg_addr;
         SEL_ABS: npc = abs_addr;
         SEL_BR:  npc = br_addr;
         default: npc = seq_addr;
      endcase
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int IMM_W      = 16,
   parameter int JADDR_W    = 26,
   parameter bit LE_VIA_SUB = 1'b0
) (
   input  logic [XLEN-1:0]    pc_i,
   input  logic [IMM_W-1:0]   imm_i,
   input  logic [JADDR_W-1:0] jaddr_i,
   input  logic [XLEN-1:0]    rs_val_i,
   input  logic [XLEN-1:0]    rt_val_i,
   input  logic               br_en_i,
   input  logic [1:0]         br_kind_i,
   input  logic               jmp_i,
   input  logic               jreg_i,
   output logic [XLEN-1:0]    npc_o,
   output logic [XLEN-1:0]    link_o
);
   generate
      if (XLEN < JADDR_W + 3) begin : g_bad_jaddr
         $error("npc_unit: XLEN too small for the jump field plus region bits");
      end
      if (XLEN < IMM_W + 3) begin : g_bad_imm
         $error("npc_unit: XLEN too small for the shifted immediate");
      end
   endgenerate

   logic [XLEN-1:0] seq_w;
   logic [XLEN-1:0] br_w;
   logic            cond_w;
   npc_sel_e        sel_w;

   npc_adders #(.XLEN(XLEN), .IMM_W(IMM_W)) u_add (
      .pc       (pc_i),
      .imm      (imm_i),
      .seq_addr (seq_w),
      .br_addr  (br_w)
   );

   npc_cond #(.XLEN(XLEN), .LE_VIA_SUB(LE_VIA_SUB)) u_cond (
      .rs   (rs_val_i),
      .rt   (rt_val_i),
      .kind (br_kind_e'(br_kind_i)),
      .cond (cond_w)
   );

   npc_select #(.XLEN(XLEN), .JADDR_W(JADDR_W)) u_sel (
      .pc       (pc_i),
      .seq_addr (seq_w),
      .br_addr  (br_w),
      .jaddr    (jaddr_i),
      .reg_addr (rs_val_i),
      .br_en    (br_en_i),
      .cond     (cond_w),
      .jmp      (jmp_i),
      .jreg     (jreg_i),
      .sel      (sel_w),
      .npc      (npc_o)
   );

   assign link_o = seq_w;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
   import npc_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int IMM_W   = 16,
   parameter int JADDR_W = 26
) (
   input logic [XLEN-1:0]    pc_i,
   input logic [IMM_W-1:0]   imm_i,
   input logic [JADDR_W-1:0] jaddr_i,
   input logic [XLEN-1:0]    rs_val_i,
   input logic [XLEN-1:0]    rt_val_i,
   input logic               br_en_i,
   input logic [1:0]         br_kind_i,
   input logic               jmp_i,
   input logic               jreg_i,
   input logic [XLEN-1:0]    npc_o,
   input logic [XLEN-1:0]    link_o,
   input npc_sel_e           sel
);
   localparam int EXT_W = XLEN - IMM_W - 2;

   logic            known;
   logic [XLEN-1:0] offs;

   assign known = !$isunknown({pc_i, imm_i, jaddr_i, rs_val_i, rt_val_i,
                               br_en_i, br_kind_i, jmp_i, jreg_i, npc_o, link_o});
   assign offs  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};

   always_comb begin
      if (known) begin
         if (!jreg_i && !jmp_i && !br_en_i)
            AST_SEQ_DEFAULT: assert (npc_o == link_o && sel == SEL_SEQ); // R1
         if (jreg_i)
            AST_JREG_WINS: assert (npc_o == rs_val_i && sel == SEL_REG); // R9
         if (!jreg_i && jmp_i)
            AST_ABS_TARGET: assert (npc_o[1:0] == 2'b00 && npc_o[XLEN-1:JADDR_W+2] == pc_i[XLEN-1:JADDR_W+2] && npc_o[JADDR_W+1:2] == jaddr_i); // R8
         if (!jreg_i && !jmp_i && br_en_i)
            AST_BR_OUTCOME: assert ((npc_o == link_o + offs) || (npc_o == link_o)); // R3
         if (!jreg_i && !jmp_i && br_en_i && br_kind_i == 2'b11 && rs_val_i[XLEN-1])
            AST_LTZ_TAKEN: assert (npc_o == link_o + offs); // R7
         if (!jreg_i && !jmp_i && br_en_i && br_kind_i == 2'b10 && rs_val_i == '0)
            AST_NEZ_ZERO: assert (npc_o == link_o); // R6
         AST_LINK_STEP: assert (link_o - pc_i == XLEN'(4)); // R2
      end
   end
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .JADDR_W(JADDR_W)) u_chk (
   .pc_i      (pc_i),
   .imm_i     (imm_i),
   .jaddr_i   (jaddr_i),
   .rs_val_i  (rs_val_i),
   .rt_val_i  (rt_val_i),
   .br_en_i   (br_en_i),
   .br_kind_i (br_kind_i),
   .jmp_i     (jmp_i),
   .jreg_i    (jreg_i),
   .npc_o     (npc_o),
   .link_o    (link_o),
   .sel       (sel_w)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [31:0] pc = '0;
   logic [15:0] imm = '0;
   logic [25:0] jaddr = '0;
   logic [31:0] rs = '0;
   logic [31:0] rt = '0;
   logic        br_en = 1'b0;
   logic [1:0]  kind = 2'b00;
   logic        jmp = 1'b0;
   logic        jreg = 1'b0;
   logic [31:0] npc;
   logic [31:0] link;

   npc_unit uut (
      .pc_i(pc), .imm_i(imm), .jaddr_i(jaddr), .rs_val_i(rs), .rt_val_i(rt),
      .br_en_i(br_en), .br_kind_i(kind), .jmp_i(jmp), .jreg_i(jreg),
      .npc_o(npc), .link_o(link)
   );

   typedef struct {
      logic [31:0] npc;
      logic [31:0] link;
      string       tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   function automatic logic [31:0] model(input logic [31:0] p, input logic [15:0] i,
                                         input logic [25:0] ja, input logic [31:0] a,
                                         input logic [31:0] b, input logic be,
                                         input logic [1:0] k, input logic j, input logic jr);
      logic [31:0] nxt;
      logic        ok;
      nxt = p + 32'd4;
      case (k)
         2'b00: ok = (a == b);
         2'b01: ok = ($signed(a) <= $signed(b));
         2'b10: ok = (a != 32'd0);
         default: ok = a[31];
      endcase
      if (jr)
         return a;
      if (j)
         return {p[31:28], ja, 2'b00};
      if (be && ok)
         return nxt + {{14{i[15]}}, i, 2'b00};
      return nxt;
   endfunction

   task automatic drive(input logic [31:0] p, input logic [15:0] i, input logic [25:0] ja,
                        input logic [31:0] a, input logic [31:0] b, input logic be,
                        input logic [1:0] k, input logic j, input logic jr, input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      pc = p; imm = i; jaddr = ja; rs = a; rt = b;
      br_en = be; kind = k; jmp = j; jreg = jr;
      e.npc  = model(p, i, ja, a, b, be, k, j, jr);
      e.link = p + 32'd4;
      e.tag  = tag;
      q.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (npc !== e.npc) begin
               failures++;
               $display("FAIL %s npc actual=%h expected=%h", e.tag, npc, e.npc);
            end
            checks++;
            if (link !== e.link) begin
               failures++;
               $display("FAIL %s link actual=%h expected=%h", e.tag, link, e.link);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stimulus
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: PC starts at 0, controls idle
      drive(32'h0, 16'h0, 26'h0, 32'h0, 32'h0, 1'b0, 2'b00, 1'b0, 1'b0, "R1 reset sequential");
      drive(32'h0000_1230, 16'h7, 26'h155, 32'h5, 32'h5, 1'b0, 2'b00, 1'b0, 1'b0, "R1 R4 br_en low ignores equal");
      // R3 forward / backward, equality
      drive(32'h0000_0100, 16'h0003, 26'h0, 32'hA, 32'hA, 1'b1, 2'b00, 1'b0, 1'b0, "R3 forward beq");
      drive(32'h0000_0200, 16'hFFFE, 26'h0, 32'hA, 32'hA, 1'b1, 2'b00, 1'b0, 1'b0, "R3 backward beq");
      drive(32'h0000_0200, 16'h8000, 26'h0, 32'h1, 32'h1, 1'b1, 2'b00, 1'b0, 1'b0, "R3 most negative offset");
      drive(32'h0000_0200, 16'h0010, 26'h0, 32'hA, 32'hB, 1'b1, 2'b00, 1'b0, 1'b0, "R4 beq unequal");
      // R5 signed ble
      drive(32'h0000_0400, 16'h0004, 26'h0, 32'hFFFF_FFFB, 32'h3, 1'b1, 2'b01, 1'b0, 1'b0, "R5 ble neg<=pos");
      drive(32'h0000_0400, 16'hFFF0, 26'h0, 32'h5, 32'h5, 1'b1, 2'b01, 1'b0, 1'b0, "R5 ble equal");
      drive(32'h0000_0400, 16'h0004, 26'h0, 32'h3, 32'hFFFF_FFFF, 1'b1, 2'b01, 1'b0, 1'b0, "R5 ble pos vs neg not taken");
      drive(32'h0000_0400, 16'h0004, 26'h0, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 2'b01, 1'b0, 1'b0, "R5 ble extremes");
      // R6 bnez
      drive(32'h0000_0500, 16'h0020, 26'h0, 32'h0, 32'h7, 1'b1, 2'b10, 1'b0, 1'b0, "R6 bnez zero rt ignored");
      drive(32'h0000_0500, 16'hFFFC, 26'h0, 32'h1, 32'h0, 1'b1, 2'b10, 1'b0, 1'b0, "R6 bnez nonzero");
      // R7 bltz
      drive(32'h0000_0600, 16'h0002, 26'h0, 32'h8000_0000, 32'h0, 1'b1, 2'b11, 1'b0, 1'b0, "R7 bltz negative");
      drive(32'h0000_0600, 16'h0002, 26'h0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 2'b11, 1'b0, 1'b0, "R7 bltz positive rt ignored");
      // R8 absolute jump
      drive(32'hA000_0010, 16'h0, 26'h000_0040, 32'h0, 32'h0, 1'b0, 2'b00, 1'b1, 1'b0, "R8 jump region");
      drive(32'h3FFF_FFFC, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0, 1'b0, 2'b00, 1'b1, 1'b0, "R8 jump region edge");
      // R9 jump register
      drive(32'h0000_0700, 16'h0, 26'h0, 32'h0000_1234, 32'h0, 1'b0, 2'b00, 1'b0, 1'b1, "R9 jump register");
      // R10 priority
      drive(32'h0000_0800, 16'h0010, 26'h0AB, 32'h0000_2000, 32'h0000_2000, 1'b1, 2'b00, 1'b1, 1'b1, "R10 jreg over all");
      drive(32'h0000_0800, 16'h0010, 26'h0AB, 32'h5, 32'h5, 1'b1, 2'b00, 1'b1, 1'b0, "R10 jump over branch");
      // R2 wrap of sequential address
      drive(32'hFFFF_FFFC, 16'h0, 26'h0, 32'h0, 32'h1, 1'b0, 2'b00, 1'b0, 1'b0, "R2 link wrap");
      drive(32'hFFFF_FFFC, 16'h0001, 26'h0, 32'hFFFF_FFFF, 32'h0, 1'b1, 2'b11, 1'b0, 1'b0, "R2 R3 branch past wrap");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule